// File: doc/BRIEF.md
# Halt-Mode Wake and Event Flag Controller

This block manages the low-power halt state of a small four-bit controller and the sticky event flags that end it. It watches five event sources: a change on the S input port, a change on the M input port, a change on the external interrupt pin, a wrap of a free-running 15-stage clock divider, and an underflow of a 6-bit reloading down-timer. Each source has its own latched flag. Software reads the flags, clears them with a write-one-to-clear strobe, and chooses for each source whether it may wake the core and whether it may raise an interrupt.

While halted, the block holds the core clock enable low. The divider and the timer keep counting, and the divider's top stage keeps driving the LCD alternation output. A wake-enabled event restarts the core clock on the edge where it is detected. An event whose wake enable is off still sets its flag, but the core stays halted.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After synchronous reset, `flags` is 0, `core_clk_en` is 1, `irq` is 0, `tmr_count` is 0, the timer is idle and the divider is at 0.
- R2: Each of the S port, the M port and the interrupt pin is compared with its sample from the previous clock. If any bit differs, the source's flag is set at that edge. The flag bits are S=bit 0, M=bit 1, interrupt pin=bit 2, divider=bit 3 and timer=bit 4. The first edge after reset is used only to take a sample and never raises a change.
- R3: The divider is a 15-bit counter that advances on every clock, halted or not. At the edge where it wraps from all ones to zero it sets flag bit 3. `lcd_alt` follows its top stage, so the first wrap happens on the 32768th edge after reset.
- R4: A `tmr_load` pulse captures `tmr_preset` into the count and the reload register and starts the timer. After that the count drops by one per clock. At the edge after the count reaches 0, flag bit 4 is set and the preset is reloaded, giving a period of preset+1 clocks. The timer keeps running in halt.
- R5: A flag stays set until software clears it with a 1 in the matching bit of `flag_clr`. If a clear and a new event for the same source arrive in the same cycle, the flag stays set.
- R6: When the core is running and asserts `halt_req`, and no flag or event is both active and wake-enabled, `core_clk_en` goes low at the next edge.
- R7: While halted, an event on a source whose `wake_en` bit is set raises `core_clk_en` at the edge where the event is detected. An event on a source whose wake enable is off sets its flag and leaves the core halted.
- R8: A `halt_req` is ignored, and the core keeps running, if any wake-enabled flag is already set.
- R9: While halted, `flag_clr` has no effect on any flag.
- R10: `irq` is 1 exactly when some flag is set whose `irq_en` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock |
| rst | input | 1 | Synchronous active-high reset |
| s_port | input | 4 | S input port, watched for changes |
| m_port | input | 4 | M input port, watched for changes |
| int_pin | input | 1 | External interrupt pin, watched for changes |
| halt_req | input | 1 | Core request to enter halt |
| wake_en | input | 5 | Per-source wake enable |
| irq_en | input | 5 | Per-source interrupt enable |
| flag_clr | input | 5 | Write-one-to-clear strobe for the flags |
| tmr_load | input | 1 | Load and start the down-timer |
| tmr_preset | input | 6 | Timer preset value |
| core_clk_en | output | 1 | Core clock enable, low while halted |
| flags | output | 5 | Latched event flags |
| irq | output | 1 | Interrupt request |
| tmr_count | output | 6 | Current timer count |
| lcd_alt | output | 1 | Divider top stage, used as the LCD alternation signal |

## Verification
The bench targets several corner cases. A port that already differs from zero when reset is released must not raise a flag; a detector that does not take an initial sample would raise one. A clear that lands in the same cycle as a new event must leave the flag set; a design that gives the clear priority would lose the event. While halted, a masked source and a clear attempt must both leave the core halted with its flags untouched, and a halt request made while a wake-enabled flag is pending must be refused; a design that ignored these would either stall the core or wake it on the wrong source. Finally, the bench waits through a full divider period in halt and checks that the wake happens on exactly the 32768th edge. A divider that stalled in halt, or that was off by one stage, would wake late or never.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    localparam int NSRC = 5;

    // flag bit positions, software decodes these
    typedef enum logic [2:0] {
        SRC_SPORT = 3'd0,
        SRC_MPORT = 3'd1,
        SRC_INTP  = 3'd2,
        SRC_DIV   = 3'd3,
        SRC_TMR   = 3'd4
    } src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic {
        PWR_RUN  = 1'b0,
        PWR_HALT = 1'b1
    } pwr_state_e;

    function automatic logic any_wake(src_vec_t pend, src_vec_t en);
        return |(pend & en);
    endfunction

endpackage

// File: rtl/hw_change_det.sv
module hw_change_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic         chg
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= din;
            primed_q <= 1'b1;
        end
    end

    assign chg = primed_q & (|(din ^ prev_q));
endmodule

// File: rtl/hw_divider.sv
module hw_divider #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] cnt,
    output logic              ovf
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign ovf = &cnt;
endmodule

// File: rtl/hw_down_timer.sv
module hw_down_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         run,
    output logic         unf
);
    logic [W-1:0] reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            reload_q <= '0;
            run      <= 1'b0;
        end else if (load) begin
            count    <= preset;
            reload_q <= preset;
            run      <= 1'b1;
        end else if (run) begin
            count <= (count == '0) ? reload_q : count - 1'b1;
        end
    end

    assign unf = run & ~load & (count == '0);
endmodule

// File: rtl/hw_flag_bank.sv
module hw_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst) f_q <= 1'b0;
            else     f_q <= (f_q & ~clr[i]) | set[i];  // a new event outranks a clear
        end
        assign flags[i] = f_q;
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int S_W        = 4,
    parameter int M_W        = 4,
    parameter int DIV_STAGES = 15,
    parameter int TMR_W      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [S_W-1:0]   s_port,
    input  logic [M_W-1:0]   m_port,
    input  logic             int_pin,
    input  logic             halt_req,
    input  logic [NSRC-1:0]  wake_en,
    input  logic [NSRC-1:0]  irq_en,
    input  logic [NSRC-1:0]  flag_clr,
    input  logic             tmr_load,
    input  logic [TMR_W-1:0] tmr_preset,
    output logic             core_clk_en,
    output logic [NSRC-1:0]  flags,
    output logic             irq,
    output logic [TMR_W-1:0] tmr_count,
    output logic             lcd_alt
);
    src_vec_t              evt;
    src_vec_t              clr_eff;
    logic                  s_chg, m_chg, i_chg;
    logic                  div_ovf, tmr_unf, tmr_run;
    logic [DIV_STAGES-1:0] div_cnt;
    pwr_state_e            pwr_q, pwr_d;
    logic                  wake;

    hw_change_det #(.W(S_W)) u_sdet (.clk(clk), .rst(rst), .din(s_port), .chg(s_chg));
    hw_change_det #(.W(M_W)) u_mdet (.clk(clk), .rst(rst), .din(m_port), .chg(m_chg));
    hw_change_det #(.W(1))   u_idet (.clk(clk), .rst(rst), .din(int_pin), .chg(i_chg));

    // oscillator-side logic: never gated by halt
    hw_divider #(.STAGES(DIV_STAGES)) u_div (
        .clk(clk), .rst(rst), .cnt(div_cnt), .ovf(div_ovf)
    );

    hw_down_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .preset(tmr_preset),
        .count(tmr_count), .run(tmr_run), .unf(tmr_unf)
    );

    always_comb begin
        evt                 = '0;
        evt[int'(SRC_SPORT)] = s_chg;
        evt[int'(SRC_MPORT)] = m_chg;
        evt[int'(SRC_INTP)]  = i_chg;
        evt[int'(SRC_DIV)]   = div_ovf;
        evt[int'(SRC_TMR)]   = tmr_unf;
    end

    // the core cannot write while halted, so clears are dropped then
    assign clr_eff = (pwr_q == PWR_HALT) ? '0 : flag_clr;

    hw_flag_bank #(.N(NSRC)) u_flags (
        .clk(clk), .rst(rst), .set(evt), .clr(clr_eff), .flags(flags)
    );

    assign wake = any_wake(flags | evt, wake_en);

    always_comb begin
        pwr_d = pwr_q;
        case (pwr_q)
            PWR_RUN:  if (halt_req && !wake) pwr_d = PWR_HALT;
            PWR_HALT: if (wake)              pwr_d = PWR_RUN;
            default:                         pwr_d = PWR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= PWR_RUN;
        else     pwr_q <= pwr_d;
    end

    assign core_clk_en = (pwr_q == PWR_RUN);
    assign irq         = |(flags & irq_en);
    assign lcd_alt     = div_cnt[DIV_STAGES-1];
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk
    import halt_wake_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int TMR_W      = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  halt_req,
    input logic [NSRC-1:0]       wake_en,
    input logic [NSRC-1:0]       flag_clr,
    input logic                  tmr_load,
    input logic [NSRC-1:0]       flags,
    input logic                  core_clk_en,
    input logic [NSRC-1:0]       evt,
    input logic [DIV_STAGES-1:0] div_cnt,
    input logic                  tmr_run,
    input logic [TMR_W-1:0]      tmr_count
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags == '0) && core_clk_en);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~flag_clr) != '0) |=>
            ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    // R9
    halt_noclr_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && flags != '0) |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    halt_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && halt_req && (((flags | evt) & wake_en) == '0)) |=> !core_clk_en);

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && ((evt & wake_en) != '0)) |=> core_clk_en);

    // R8
    halt_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && ((flags & wake_en) != '0)) |=> core_clk_en);

    // R3
    div_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (div_cnt == '1) |=> flags[int'(SRC_DIV)]);

    // R4
    tmr_unf_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_run && !tmr_load && tmr_count == '0) |=> flags[int'(SRC_TMR)] && tmr_run);
endmodule

bind halt_wake_ctrl halt_wake_chk #(.DIV_STAGES(DIV_STAGES), .TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wake_en(wake_en),
    .flag_clr(flag_clr), .tmr_load(tmr_load), .flags(flags),
    .core_clk_en(core_clk_en), .evt(evt), .div_cnt(div_cnt),
    .tmr_run(tmr_run), .tmr_count(tmr_count)
);

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_MOD    = 32768;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] s_port = '0, m_port = '0;
    logic       int_pin = 1'b0, halt_req = 1'b0, tmr_load = 1'b0;
    logic [4:0] wake_en = '0, irq_en = '0, flag_clr = '0;
    logic [5:0] tmr_preset = '0;
    logic       core_clk_en, irq, lcd_alt;
    logic [4:0] flags;
    logic [5:0] tmr_count;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    halt_wake_ctrl u_dut (
        .clk(clk), .rst(rst), .s_port(s_port), .m_port(m_port), .int_pin(int_pin),
        .halt_req(halt_req), .wake_en(wake_en), .irq_en(irq_en), .flag_clr(flag_clr),
        .tmr_load(tmr_load), .tmr_preset(tmr_preset), .core_clk_en(core_clk_en),
        .flags(flags), .irq(irq), .tmr_count(tmr_count), .lcd_alt(lcd_alt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // behavioural reference model
    int m_flags, m_div, m_tcnt, m_tpre, ps, pm, pi;
    bit m_halt, m_trun, m_primed;

    always @(posedge clk) begin
        int ev, clr;
        bit wk;
        if (rst) begin
            m_flags = 0; m_div = 0; m_tcnt = 0; m_tpre = 0;
            m_halt = 0; m_trun = 0; m_primed = 0; ps = 0; pm = 0; pi = 0;
            cyc = 0;
        end else begin
            cyc++;
            ev = 0;
            if (m_primed && int'(s_port) != ps) ev |= 1;
            if (m_primed && int'(m_port) != pm) ev |= 2;
            if (m_primed && int'(int_pin) != pi) ev |= 4;
            if (m_div == DIV_MOD - 1) ev |= 8;
            if (m_trun && !tmr_load && m_tcnt == 0) ev |= 16;
            clr = m_halt ? 0 : int'(flag_clr);
            wk = (((m_flags | ev) & int'(wake_en)) != 0);
            m_flags = ((m_flags & ~clr) | ev) & 31;
            if (m_halt) m_halt = !wk;
            else        m_halt = halt_req && !wk;
            m_div = (m_div + 1) % DIV_MOD;
            if (tmr_load) begin
                m_tcnt = int'(tmr_preset); m_tpre = int'(tmr_preset); m_trun = 1;
            end else if (m_trun) begin
                m_tcnt = (m_tcnt == 0) ? m_tpre : m_tcnt - 1;
            end
            ps = int'(s_port); pm = int'(m_port); pi = int'(int_pin);
            m_primed = 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 R4 R5 flags vs model", int'(flags), m_flags);
            chk("R6 R7 core_clk_en vs model", int'(core_clk_en), int'(!m_halt));
            chk("R10 irq vs model", int'(irq), int'((m_flags & int'(irq_en)) != 0));
            chk("R4 tmr_count vs model", int'(tmr_count), m_tcnt);
            chk("R3 lcd_alt vs model", int'(lcd_alt), (m_div >> 14) & 1);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        s_port = 4'h5;                 // nonzero while in reset
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 flags after reset", int'(flags), 0);
        chk("R1 core_clk_en after reset", int'(core_clk_en), 1);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 tmr_count after reset", int'(tmr_count), 0);
        chk("R2 no change on first sample", int'(flags), 0);
        tick();

        s_port = 4'h4; tick();
        chk("R2 S port change", int'(flags), 5'b00001);
        m_port = 4'h8; tick();
        chk("R2 M port change", int'(flags), 5'b00011);
        int_pin = 1'b1; tick();
        chk("R2 INT change", int'(flags), 5'b00111);
        tick();
        chk("R5 flags sticky", int'(flags), 5'b00111);

        irq_en = 5'b00100; #1;
        chk("R10 irq enabled source", int'(irq), 1);
        irq_en = 5'b01000; #1;
        chk("R10 irq masked source", int'(irq), 0);
        irq_en = '0;

        flag_clr = 5'b00011; tick(); flag_clr = '0;
        chk("R5 clear", int'(flags), 5'b00100);
        flag_clr = 5'b00100; int_pin = 1'b0; tick(); flag_clr = '0;
        chk("R5 clear with same-cycle event", int'(flags), 5'b00100);
        flag_clr = 5'b00100; tick(); flag_clr = '0;
        chk("R5 clear INT", int'(flags), 0);

        tmr_preset = 6'd5; tmr_load = 1'b1; tick(); tmr_load = 1'b0;
        chk("R4 load", int'(tmr_count), 5);
        repeat (5) tick();
        chk("R4 count reaches zero", int'(tmr_count), 0);
        chk("R4 no flag before underflow", int'(flags[4]), 0);
        tick();
        chk("R4 underflow flag", int'(flags[4]), 1);
        chk("R4 reload", int'(tmr_count), 5);

        flag_clr = 5'b11111; tick(); flag_clr = '0;
        wake_en = 5'b00100;
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        chk("R6 halt entered", int'(core_clk_en), 0);
        s_port = s_port ^ 4'h1; tick();
        chk("R7 masked flag set", int'(flags[0]), 1);
        chk("R7 masked source no wake", int'(core_clk_en), 0);
        flag_clr = 5'b00001; tick(); flag_clr = '0;
        chk("R9 clear ignored in halt", int'(flags[0]), 1);
        repeat (8) tick();
        chk("R4 timer runs in halt", int'(flags[4]), 1);
        chk("R7 still halted", int'(core_clk_en), 0);
        int_pin = 1'b1; tick();
        chk("R7 wake on INT", int'(core_clk_en), 1);
        chk("R7 INT flag", int'(flags[2]), 1);

        halt_req = 1'b1; tick(); halt_req = 1'b0;
        chk("R8 halt refused with pending flag", int'(core_clk_en), 1);

        flag_clr = 5'b11111; tick(); flag_clr = '0;
        wake_en = 5'b01000;
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        chk("R6 halt for divider wait", int'(core_clk_en), 0);
        for (int k = 0; k < 40000 && !core_clk_en; k++) tick();
        chk("R3 divider wake", int'(core_clk_en), 1);
        chk("R3 divider flag", int'(flags[3]), 1);
        chk("R3 wake edge", cyc, DIV_MOD);
        chk("R3 lcd_alt after wrap", int'(lcd_alt), 0);

        done = 1;
        finish_run();
    end
endmodule